// File: doc/BRIEF.md
# Five-Way Redundant Output Voter

This block takes the outputs of five identical copies of a module and returns one result that at least three of the copies agree on. It does this without a bitwise vote. It compares every pair of copies for equality, which gives ten mismatch flags. From those flags it finds which copies agree with a majority. A priority encoder then picks the lowest-numbered agreeing copy, and a multiplexer forwards that copy's word. The logic is purely combinational, so the result settles in the same cycle as the inputs.

The ten pair flags and a per-copy disagreement vector are brought out to the ports. A recovery controller can use them to find which copies need their state repaired. The block also gives a summary error flag, and a flag that warns when no value is held by three or more copies. In that case the block falls back to the first copy.

Top module: `fmv_voter`

## Requirements
- R1: `pair_err` has one bit per unordered pair of copies, in this order: bit 0 = (0,1), bit 1 = (0,2), bit 2 = (0,3), bit 3 = (0,4), bit 4 = (1,2), bit 5 = (1,3), bit 6 = (1,4), bit 7 = (2,3), bit 8 = (2,4), bit 9 = (3,4). A bit is 1 exactly when the two words of its pair differ.
- R2: `any_error` is 1 exactly when the five input words are not all equal.
- R3: `mod_disagree[i]` is 1 exactly when copy i equals fewer than two of the other four copies.
- R4: When a majority exists, `sel_code` is the lowest 0-based index of a copy that equals at least two other copies.
- R5: When some value is held by three or more copies, `voted_out` equals that value.
- R6: When no value is held by three or more copies, `no_majority` is 1, `sel_code` is 0 and `voted_out` equals copy 0. Otherwise `no_majority` is 0.
- R7: When exactly one copy differs from the other four, exactly the four `pair_err` bits that involve that copy are 1.
- R8: When all five copies are equal, `pair_err`, `mod_disagree`, `any_error`, `no_majority` and `sel_code` are all 0, and `voted_out` equals the common word.
- R9: When two faulty copies carry the same wrong word, the pair bit between them stays 0, both are flagged in `mod_disagree`, and `voted_out` still gives the majority word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rep_in | input | 5 x WIDTH | Words from the five replicated copies, index 0..4 |
| voted_out | output | WIDTH | Word of the selected copy |
| pair_err | output | 10 | Pairwise mismatch flags, ordered as in R1 |
| mod_disagree | output | 5 | Copy is outside the majority |
| sel_code | output | 3 | Index of the selected copy |
| no_majority | output | 1 | No word is shared by three copies |
| any_error | output | 1 | Some pair mismatches |

## Verification
The hardest case to reach is two faulty copies that agree with each other. In that case the faulty pair bit stays clear while the faulty copies still have to be flagged, and random words almost never produce it. The stimulus therefore drives every placement of two faulty copies twice: once with two different corrupt words, and once with one shared corrupt word. It then adds cases with three copies corrupted, both scattered and identical, to reach the boundary where the majority either fails or moves to the corrupt value.

// File: rtl/fmv_pkg.sv
package fmv_pkg;
    localparam int NMOD  = 5;
    localparam int NPAIR = NMOD * (NMOD - 1) / 2;
    localparam int SELW  = $clog2(NMOD);
    localparam int CNTW  = $clog2(NMOD);

    // lower member of pair k, pairs enumerated (0,1),(0,2)..(NMOD-2,NMOD-1)
    function automatic int pair_lo(input int k);
        int idx;
        idx = 0;
        pair_lo = 0;
        for (int a = 0; a < NMOD; a++) begin
            for (int b = a + 1; b < NMOD; b++) begin
                if (idx == k) pair_lo = a;
                idx++;
            end
        end
    endfunction

    function automatic int pair_hi(input int k);
        int idx;
        idx = 0;
        pair_hi = 0;
        for (int a = 0; a < NMOD; a++) begin
            for (int b = a + 1; b < NMOD; b++) begin
                if (idx == k) pair_hi = b;
                idx++;
            end
        end
    endfunction
endpackage

// File: rtl/fmv_pair_cmp.sv
module fmv_pair_cmp
    import fmv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [NMOD-1:0][WIDTH-1:0] words,
    output logic [NPAIR-1:0]           mismatch
);
    for (genvar k = 0; k < NPAIR; k++) begin : g_cmp
        localparam int LO = pair_lo(k);
        localparam int HI = pair_hi(k);
        assign mismatch[k] = |(words[LO] ^ words[HI]);
    end
endmodule

// File: rtl/fmv_agree.sv
module fmv_agree
    import fmv_pkg::*;
(
    input  logic [NPAIR-1:0] mismatch,
    output logic [NMOD-1:0]  agree
);
    for (genvar m = 0; m < NMOD; m++) begin : g_mod
        logic [CNTW-1:0] match_cnt_d;
        always_comb begin
            match_cnt_d = '0;
            for (int k = 0; k < NPAIR; k++) begin
                if ((pair_lo(k) == m || pair_hi(k) == m) && !mismatch[k])
                    match_cnt_d = match_cnt_d + CNTW'(1);
            end
        end
        assign agree[m] = (match_cnt_d >= CNTW'(2));
    end
endmodule

// File: rtl/fmv_sel_enc.sv
module fmv_sel_enc
    import fmv_pkg::*;
(
    input  logic [NMOD-1:0] agree,
    output logic [SELW-1:0] sel,
    output logic            none
);
    always_comb begin
        sel  = '0;
        none = ~|agree;
        for (int m = NMOD - 1; m >= 0; m--) begin
            if (agree[m]) sel = SELW'(m);
        end
    end
endmodule

// File: rtl/fmv_voter.sv
module fmv_voter
    import fmv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [NMOD-1:0][WIDTH-1:0] rep_in,
    output logic [WIDTH-1:0]           voted_out,
    output logic [NPAIR-1:0]           pair_err,
    output logic [NMOD-1:0]            mod_disagree,
    output logic [SELW-1:0]            sel_code,
    output logic                       no_majority,
    output logic                       any_error
);
    logic [NMOD-1:0] agree;

    fmv_pair_cmp #(.WIDTH(WIDTH)) u_cmp (
        .words    (rep_in),
        .mismatch (pair_err)
    );

    fmv_agree u_agree (
        .mismatch (pair_err),
        .agree    (agree)
    );

    fmv_sel_enc u_enc (
        .agree (agree),
        .sel   (sel_code),
        .none  (no_majority)
    );

    always_comb begin
        voted_out = rep_in[0];
        for (int m = 1; m < NMOD; m++) begin
            if (sel_code == SELW'(m)) voted_out = rep_in[m];
        end
    end

    assign mod_disagree = ~agree;
    assign any_error    = |pair_err;
endmodule

// File: rtl/fmv_voter_chk.sv
module fmv_voter_chk
    import fmv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [NMOD-1:0][WIDTH-1:0] rep_in,
    input logic [WIDTH-1:0]           voted_out,
    input logic [NPAIR-1:0]           pair_err,
    input logic [NMOD-1:0]            mod_disagree,
    input logic [SELW-1:0]            sel_code,
    input logic                       no_majority,
    input logic                       any_error
);
    always_comb begin
        logic all_eq;
        int   hold;
        all_eq = 1'b1;
        hold   = 0;
        for (int m = 0; m < NMOD; m++) begin
            if (rep_in[m] != rep_in[0]) all_eq = 1'b0;
            if (rep_in[m] == voted_out) hold++;
        end
        p_any_err_r2: assert (any_error == !all_eq)
            else $error("any_error disagrees with input equality");
        p_sel_range_r4: assert (int'(sel_code) < NMOD)
            else $error("sel_code out of range");
        p_out_majority_r5: assert (no_majority || hold >= 3)
            else $error("voted word not held by three copies");
        p_fallback_r6: assert (!no_majority || (sel_code == '0 && voted_out == rep_in[0]))
            else $error("fallback select wrong");
        p_disagree_r3: assert (no_majority ? (&mod_disagree) : ($countones(mod_disagree) <= 2))
            else $error("disagreement vector inconsistent");
        p_clean_r8: assert (!all_eq || (pair_err == '0 && mod_disagree == '0))
            else $error("flags set with equal inputs");
    end
endmodule

bind fmv_voter fmv_voter_chk #(.WIDTH(WIDTH)) u_chk (
    .rep_in       (rep_in),
    .voted_out    (voted_out),
    .pair_err     (pair_err),
    .mod_disagree (mod_disagree),
    .sel_code     (sel_code),
    .no_majority  (no_majority),
    .any_error    (any_error)
);

// File: tb/sim_fmv_voter.sv
`timescale 1ns/1ps
module sim_fmv_voter;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4:0][W-1:0] rep_in;
    logic [W-1:0]      voted_out;
    logic [9:0]        pair_err;
    logic [4:0]        mod_disagree;
    logic [2:0]        sel_code;
    logic              no_majority;
    logic              any_error;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    fmv_voter #(.WIDTH(W)) u0 (
        .rep_in(rep_in), .voted_out(voted_out), .pair_err(pair_err),
        .mod_disagree(mod_disagree), .sel_code(sel_code),
        .no_majority(no_majority), .any_error(any_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected outputs from the requirements
    task automatic apply_check(input logic [4:0][W-1:0] v);
        logic [9:0]   e_pair;
        logic [4:0]   e_dis;
        logic [2:0]   e_sel;
        logic         e_nomaj;
        logic [W-1:0] e_out;
        int k;
        int cnt;
        @(posedge clk);
        rep_in = v;
        k = 0;
        for (int a = 0; a < 5; a++)
            for (int b = a + 1; b < 5; b++) begin
                e_pair[k] = (v[a] != v[b]);
                k++;
            end
        e_nomaj = 1'b1;
        e_sel   = 3'd0;
        for (int m = 4; m >= 0; m--) begin
            cnt = 0;
            for (int o = 0; o < 5; o++) if (o != m && v[o] == v[m]) cnt++;
            e_dis[m] = (cnt < 2);
            if (cnt >= 2) begin
                e_nomaj = 1'b0;
                e_sel   = 3'(m);
            end
        end
        e_out = v[e_sel];
        @(negedge clk);
        chk("R1 pair_err", 32'(pair_err), 32'(e_pair));
        chk("R2 any_error", 32'(any_error), 32'(e_pair != 0));
        chk("R3 mod_disagree", 32'(mod_disagree), 32'(e_dis));
        chk("R4 sel_code", 32'(sel_code), 32'(e_sel));
        chk("R5 voted_out", 32'(voted_out), 32'(e_out));
        chk("R6 no_majority", 32'(no_majority), 32'(e_nomaj));
    endtask

    task automatic t_reset_state();
        apply_check('0);
        chk("R8 idle errors", 32'(any_error), 32'd0);
    endtask

    task automatic t_all_equal();
        apply_check({5{8'hA5}});
        chk("R8 all equal out", 32'(voted_out), 32'hA5);
        chk("R8 all equal sel", 32'(sel_code), 32'd0);
    endtask

    task automatic t_single_fault();
        for (int f = 0; f < 5; f++) begin
            logic [4:0][W-1:0] v;
            logic [9:0] e4;
            int k;
            v = {5{8'h3C}};
            v[f] = 8'h3C ^ (8'h01 << f);
            apply_check(v);
            k = 0;
            e4 = '0;
            for (int a = 0; a < 5; a++)
                for (int b = a + 1; b < 5; b++) begin
                    if (a == f || b == f) e4[k] = 1'b1;
                    k++;
                end
            chk("R7 single fault pairs", 32'(pair_err), 32'(e4));
            chk("R7 four bits set", 32'($countones(pair_err)), 32'd4);
        end
    endtask

    task automatic t_two_faults();
        for (int a = 0; a < 5; a++)
            for (int b = a + 1; b < 5; b++) begin
                logic [4:0][W-1:0] v;
                v = {5{8'h5A}};
                v[a] = 8'h11; v[b] = 8'h22;
                apply_check(v);
                chk("R5 distinct faults out", 32'(voted_out), 32'h5A);
                v[b] = 8'h11;
                apply_check(v);
                chk("R9 common fault out", 32'(voted_out), 32'h5A);
                chk("R9 common fault flags", 32'(mod_disagree), 32'((5'b1 << a) | (5'b1 << b)));
            end
    endtask

    task automatic t_three_faults();
        apply_check({8'h01, 8'h02, 8'h03, 8'h77, 8'h77});
        chk("R6 scattered no majority", 32'(no_majority), 32'd1);
        chk("R6 fallback out", 32'(voted_out), 32'h77);
        apply_check({8'h77, 8'h77, 8'h99, 8'h99, 8'h99});
        chk("R5 majority moves to corrupt", 32'(voted_out), 32'h99);
        chk("R4 lowest agreeing", 32'(sel_code), 32'd0);
        apply_check({8'h99, 8'h99, 8'h99, 8'h77, 8'h77});
        chk("R4 sel skips low copies", 32'(sel_code), 32'd2);
    endtask

    task automatic t_all_distinct();
        apply_check({8'h50, 8'h40, 8'h30, 8'h20, 8'h10});
        chk("R6 all distinct flag", 32'(no_majority), 32'd1);
        chk("R6 all distinct sel", 32'(sel_code), 32'd0);
        chk("R6 all distinct out", 32'(voted_out), 32'h10);
    endtask

    initial begin
        rep_in = '0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_all_equal();
        t_single_fault();
        t_two_faults();
        t_three_faults();
        t_all_distinct();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule